// File: doc/BRIEF.md
# Power-Up Serial Configuration Loader

This block brings a set of board-level analog helpers into a known state right after reset. It first waits a fixed power-settling interval. It then drives a three-wire serial bus made of a shared serial clock, a shared data line and one load strobe per target. Over that bus it writes default settings into two kinds of target, in a fixed order.

The first target is a cascade of ten programmable delay devices, each feeding its serial output into the next. Because of the cascade, the whole chain is written as one 80-bit frame. That frame carries one 8-bit code per device in programming order, and each code goes out most significant bit first. Each device delays its signal by 10 ns plus 0.25 ns per code step.

The second target is a pair of converter channels with eight registers each. Every register is written as a separate short frame under that channel's own strobe. When all frames are out, the loader raises a sticky completion flag and drops its bus-ownership output, so that another master can take over the serial lines.

Top module: `boot_serial_loader`

## Requirements
- R1: After reset is released, no load strobe rises and no serial clock pulse occurs for at least PWR_WAIT_CYCLES clock cycles. The first frame begins no more than 8 cycles after that interval.
- R2: The first frame is one 80-bit frame under `dly_load`. It carries the ten delay codes 32, 24, 24, 20, 20, 0, 0, 0, 0, 0 in that order, each code MSB first.
- R3: No converter strobe is raised before the delay-chain frame has ended.
- R4: After the delay frame come 16 converter frames of 11 bits each. Channel A registers 0..7 go first, under `cha_load`, then channel B registers 0..7, under `chb_load`. Each frame sends a 3-bit register address LSB first, followed by 8 data bits LSB first.
- R5: Registers 0..7 of both channels receive 128, 206, 96, 10, 43, 43, 43, 43.
- R6: At most one load strobe is high at any time, and the serial clock only pulses while a strobe is high. A strobe stays high from before the first clock rise of its frame until after the last one.
- R7: `ser_dat` changes only while `ser_clk` is low, so it is stable during every high phase.
- R8: During reset, `ser_clk`, `ser_dat` and all strobes are low, `boot_done` is 0 and `ser_oe` is 1.
- R9: Every high phase of `ser_clk` lasts exactly CLK_HALF clock cycles.
- R10: Between the end of one frame and the start of the next, all strobes stay low for at least GAP_CYCLES cycles.
- R11: `boot_done` rises exactly once, after the final frame and its gap. It then stays high, and from then on `ser_oe` is 0 and the clock, data and strobe outputs stay low.
- R12: A reset asserted in the middle of a load returns the outputs to the R8 state. After release, the whole sequence, including the power wait, runs again from the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | output | 1 | Shared serial clock, idle low |
| ser_dat | output | 1 | Shared serial data, valid on `ser_clk` rising edge |
| dly_load | output | 1 | Active-high load strobe for the delay chain |
| cha_load | output | 1 | Active-high load strobe for converter channel A |
| chb_load | output | 1 | Active-high load strobe for converter channel B |
| ser_oe | output | 1 | High while the loader owns the serial bus; low releases it |
| boot_done | output | 1 | Sticky flag: all default settings have been written |

## Verification
The hardest situation to reach from the ports is a reset that lands partway through a frame. The shift register, bit counter and divider are then all mid-flight, and a stale value would show up as a short or corrupt first frame on the restart. The stimulus runs one full boot, starts a second boot, waits until the delay-chain strobe has been high for a hundred cycles, and pulls reset there. It then checks the reset state and decodes a complete third boot bit by bit. A bus monitor rebuilds every frame from the clock rises. It also measures high-phase lengths and inter-frame gaps, and so catches data edges during a high phase and overlapping strobes.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    localparam int DLY_COUNT      = 10;
    localparam int DLY_CODE_W     = 8;
    localparam int REG_ADDR_W     = 3;
    localparam int REG_DATA_W     = 8;
    localparam int REG_COUNT      = 2 ** REG_ADDR_W;
    localparam int CHAN_COUNT     = 2;
    localparam int DLY_FRAME_BITS = DLY_COUNT * DLY_CODE_W;
    localparam int REG_FRAME_BITS = REG_ADDR_W + REG_DATA_W;
    localparam int FRAME_W        = DLY_FRAME_BITS;
    localparam int FRAME_COUNT    = 1 + CHAN_COUNT * REG_COUNT;
    localparam int LEN_W          = $clog2(FRAME_W + 1);
    localparam int IDX_W          = $clog2(FRAME_COUNT + 1);

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_DLY,
        TGT_CHA,
        TGT_CHB
    } target_e;

    typedef enum logic [2:0] {
        SEQ_WAIT,
        SEQ_ISSUE,
        SEQ_RUN,
        SEQ_GAP,
        SEQ_DONE
    } seq_e;

    // Programming-order default code of each delay device.
    function automatic logic [DLY_CODE_W-1:0] dly_default_code(input int unsigned pos);
        case (pos)
            0:       return DLY_CODE_W'(32);
            1, 2:    return DLY_CODE_W'(24);
            3, 4:    return DLY_CODE_W'(20);
            default: return '0;
        endcase
    endfunction

    // Default value of each converter register (same for both channels).
    function automatic logic [REG_DATA_W-1:0] reg_default_value(input logic [REG_ADDR_W-1:0] addr);
        case (addr)
            3'd0:    return REG_DATA_W'(128);
            3'd1:    return REG_DATA_W'(206);
            3'd2:    return REG_DATA_W'(96);
            3'd3:    return REG_DATA_W'(10);
            default: return REG_DATA_W'(43);
        endcase
    endfunction

endpackage

// File: rtl/pwr_wait_timer.sv
module pwr_wait_timer #(
    parameter int WAIT_CYCLES = 6_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic expired
);
    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             expired;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!tmr_q.expired) begin
            if (tmr_q.cnt == CNT_W'(WAIT_CYCLES - 1)) begin
                tmr_d.expired = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired = tmr_q.expired;

endmodule

// File: rtl/serial_frame_shifter.sv
module serial_frame_shifter
    import cfg_loader_pkg::*;
#(
    parameter int HALF_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [FRAME_W-1:0] frame_bits,
    input  logic [LEN_W-1:0] frame_len,
    output logic             active,
    output logic             finished,
    output logic             ser_clk,
    output logic             ser_dat
);
    localparam int DIV_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;

    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic [LEN_W-1:0]   bits_left;
        logic [DIV_W-1:0]   div_cnt;
        logic               high_phase;
        logic               active;
        logic               sclk;
        logic               fin;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d     = shf_q;
        shf_d.fin = 1'b0;
        if (!shf_q.active) begin
            if (start) begin
                shf_d.active     = 1'b1;
                shf_d.shreg      = frame_bits;
                shf_d.bits_left  = frame_len;
                shf_d.div_cnt    = '0;
                shf_d.high_phase = 1'b0;
                shf_d.sclk       = 1'b0;
            end
        end else if (shf_q.div_cnt == DIV_W'(HALF_CYCLES - 1)) begin
            shf_d.div_cnt = '0;
            if (!shf_q.high_phase) begin
                shf_d.high_phase = 1'b1;
                shf_d.sclk       = 1'b1;
            end else begin
                // falling edge: data moves on together with the clock drop
                shf_d.high_phase = 1'b0;
                shf_d.sclk       = 1'b0;
                if (shf_q.bits_left == LEN_W'(1)) begin
                    shf_d.active = 1'b0;
                    shf_d.fin    = 1'b1;
                    shf_d.shreg  = '0;
                end else begin
                    shf_d.shreg     = shf_q.shreg << 1;
                    shf_d.bits_left = shf_q.bits_left - 1'b1;
                end
            end
        end else begin
            shf_d.div_cnt = shf_q.div_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shf_q <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign active   = shf_q.active;
    assign finished = shf_q.fin;
    assign ser_clk  = shf_q.sclk;
    assign ser_dat  = shf_q.shreg[FRAME_W-1];

endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
    import cfg_loader_pkg::*;
#(
    parameter int GAP_CYCLES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_ok,
    input  logic               frame_fin,
    output logic               start,
    output logic [FRAME_W-1:0] frame_bits,
    output logic [LEN_W-1:0]   frame_len,
    output target_e            target,
    output logic               bus_own,
    output logic               boot_done
);
    localparam int GAP_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

    typedef struct packed {
        seq_e             state;
        logic [IDX_W-1:0] idx;
        logic [GAP_W-1:0] gap_cnt;
        target_e          target;
        logic             own;
        logic             done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [IDX_W-1:0]      conv_idx;
    logic [REG_ADDR_W-1:0] reg_sel;
    logic                  chan_b;
    logic [REG_FRAME_BITS-1:0] reg_word;

    assign conv_idx = seq_q.idx - 1'b1;
    assign reg_sel  = conv_idx[REG_ADDR_W-1:0];
    assign chan_b   = conv_idx[REG_ADDR_W];
    assign reg_word = {reg_default_value(reg_sel), reg_sel};

    // frame contents: first bit to leave sits at the MSB
    always_comb begin
        frame_bits = '0;
        if (seq_q.idx == '0) begin
            frame_len = LEN_W'(DLY_FRAME_BITS);
            for (int i = 0; i < DLY_COUNT; i++) begin
                frame_bits[FRAME_W-1-i*DLY_CODE_W -: DLY_CODE_W] = dly_default_code(i);
            end
        end else begin
            frame_len = LEN_W'(REG_FRAME_BITS);
            for (int k = 0; k < REG_FRAME_BITS; k++) begin
                frame_bits[FRAME_W-1-k] = reg_word[k];
            end
        end
    end

    always_comb begin
        seq_d = seq_q;
        start = 1'b0;
        case (seq_q.state)
            SEQ_WAIT: begin
                if (pwr_ok) begin
                    seq_d.state = SEQ_ISSUE;
                end
            end
            SEQ_ISSUE: begin
                start       = 1'b1;
                seq_d.state = SEQ_RUN;
                if (seq_q.idx == '0) begin
                    seq_d.target = TGT_DLY;
                end else if (chan_b) begin
                    seq_d.target = TGT_CHB;
                end else begin
                    seq_d.target = TGT_CHA;
                end
            end
            SEQ_RUN: begin
                if (frame_fin) begin
                    seq_d.state   = SEQ_GAP;
                    seq_d.gap_cnt = '0;
                    seq_d.target  = TGT_NONE;
                end
            end
            SEQ_GAP: begin
                if (seq_q.gap_cnt == GAP_W'(GAP_CYCLES - 1)) begin
                    if (seq_q.idx == IDX_W'(FRAME_COUNT - 1)) begin
                        seq_d.state = SEQ_DONE;
                        seq_d.done  = 1'b1;
                        seq_d.own   = 1'b0;
                    end else begin
                        seq_d.idx   = seq_q.idx + 1'b1;
                        seq_d.state = SEQ_ISSUE;
                    end
                end else begin
                    seq_d.gap_cnt = seq_q.gap_cnt + 1'b1;
                end
            end
            default: begin
                seq_d.state = SEQ_DONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= SEQ_WAIT;
            seq_q.target <= TGT_NONE;
            seq_q.own   <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign target    = seq_q.target;
    assign bus_own   = seq_q.own;
    assign boot_done = seq_q.done;

endmodule

// File: rtl/boot_serial_loader.sv
module boot_serial_loader
    import cfg_loader_pkg::*;
#(
    parameter int CLK_HALF        = 4,
    parameter int PWR_WAIT_CYCLES = 6_000_000,
    parameter int GAP_CYCLES      = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic ser_clk,
    output logic ser_dat,
    output logic dly_load,
    output logic cha_load,
    output logic chb_load,
    output logic ser_oe,
    output logic boot_done
);
    logic               pwr_ok;
    logic               start;
    logic [FRAME_W-1:0] frame_bits;
    logic [LEN_W-1:0]   frame_len;
    logic               active;
    logic               frame_fin;
    target_e            target;

    pwr_wait_timer #(
        .WAIT_CYCLES(PWR_WAIT_CYCLES)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .expired(pwr_ok)
    );

    boot_sequencer #(
        .GAP_CYCLES(GAP_CYCLES)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_ok    (pwr_ok),
        .frame_fin (frame_fin),
        .start     (start),
        .frame_bits(frame_bits),
        .frame_len (frame_len),
        .target    (target),
        .bus_own   (ser_oe),
        .boot_done (boot_done)
    );

    serial_frame_shifter #(
        .HALF_CYCLES(CLK_HALF)
    ) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .frame_bits(frame_bits),
        .frame_len (frame_len),
        .active    (active),
        .finished  (frame_fin),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat)
    );

    assign dly_load = active && (target == TGT_DLY);
    assign cha_load = active && (target == TGT_CHA);
    assign chb_load = active && (target == TGT_CHB);

endmodule

// File: rtl/boot_loader_checks.sv
module boot_loader_checks (
    input logic clk,
    input logic rst_n,
    input logic ser_clk,
    input logic ser_dat,
    input logic dly_load,
    input logic cha_load,
    input logic chb_load,
    input logic ser_oe,
    input logic boot_done
);
    logic dly_prev;
    logic dly_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_prev <= 1'b0;
            dly_seen <= 1'b0;
        end else begin
            dly_prev <= dly_load;
            if (dly_prev && !dly_load) begin
                dly_seen <= 1'b1;
            end
        end
    end

    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dly_load, cha_load, chb_load}));

    assert_clk_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> (dly_load || cha_load || chb_load));

    assert_data_stable_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_dat));

    assert_chain_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cha_load || chb_load) |-> dly_seen);

    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> boot_done);

    assert_bus_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |-> (!ser_oe && !ser_clk && !dly_load && !cha_load && !chb_load));

endmodule

bind boot_serial_loader boot_loader_checks i_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .ser_dat  (ser_dat),
    .dly_load (dly_load),
    .cha_load (cha_load),
    .chb_load (chb_load),
    .ser_oe   (ser_oe),
    .boot_done(boot_done)
);

// File: tb/test_boot_serial_loader.sv
`timescale 1ns/1ps
module test_boot_serial_loader;

    localparam int CLK_HALF = 2;
    localparam int PWR_WAIT = 300;
    localparam int GAP      = 3;
    localparam int MAX_FR   = 32;

    // expected delay-chain payload, first bit sent at bit 79
    localparam logic [79:0] EXP_CHAIN = {8'd32, 8'd24, 8'd24, 8'd20, 8'd20,
                                         8'd0, 8'd0, 8'd0, 8'd0, 8'd0};
    // expected converter writes: {channel B?, address, data}
    localparam logic [11:0] EXP_CONV [16] = '{
        {1'b0, 3'd0, 8'd128}, {1'b0, 3'd1, 8'd206}, {1'b0, 3'd2, 8'd96}, {1'b0, 3'd3, 8'd10},
        {1'b0, 3'd4, 8'd43},  {1'b0, 3'd5, 8'd43},  {1'b0, 3'd6, 8'd43}, {1'b0, 3'd7, 8'd43},
        {1'b1, 3'd0, 8'd128}, {1'b1, 3'd1, 8'd206}, {1'b1, 3'd2, 8'd96}, {1'b1, 3'd3, 8'd10},
        {1'b1, 3'd4, 8'd43},  {1'b1, 3'd5, 8'd43},  {1'b1, 3'd6, 8'd43}, {1'b1, 3'd7, 8'd43}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk, ser_dat, dly_load, cha_load, chb_load, ser_oe, boot_done;

    always #2.5 clk = ~clk;

    boot_serial_loader #(
        .CLK_HALF(CLK_HALF),
        .PWR_WAIT_CYCLES(PWR_WAIT),
        .GAP_CYCLES(GAP)
    ) i_boot_serial_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .dly_load(dly_load), .cha_load(cha_load), .chb_load(chb_load),
        .ser_oe(ser_oe), .boot_done(boot_done)
    );

    int n_run = 0;
    int n_fail = 0;

    // bus monitor state
    int          cyc, first_load, nfr, cur_n, hi_cnt, gap_cnt;
    int          v_stable, v_noload, v_multi, v_half, v_gap, v_after, done_rises;
    logic [2:0]  fr_tgt [MAX_FR];
    int          fr_len [MAX_FR];
    logic [79:0] fr_bits [MAX_FR];
    logic [79:0] cur_bits;
    logic        p_sclk, p_dat, p_done;
    logic [2:0]  p_ld;

    always @(negedge clk) begin
        logic [2:0] ld;
        ld = {dly_load, cha_load, chb_load};
        if (!rst_n) begin
            cyc = 0; first_load = -1; nfr = 0; cur_n = 0; hi_cnt = 0; gap_cnt = 0;
            v_stable = 0; v_noload = 0; v_multi = 0; v_half = 0; v_gap = 0;
            v_after = 0; done_rises = 0; cur_bits = '0;
            p_sclk = 1'b0; p_dat = 1'b0; p_done = 1'b0; p_ld = '0;
        end else begin
            cyc++;
            if ($countones(ld) > 1) v_multi++;
            if (ser_clk && ld == 3'b000) v_noload++;
            if (ser_clk && p_sclk && ser_dat != p_dat) v_stable++;
            if (ld != 3'b000 && p_ld == 3'b000) begin
                if (first_load < 0) first_load = cyc;
                if (nfr > 0 && gap_cnt < GAP) v_gap++;
                cur_bits = '0;
                cur_n = 0;
            end
            if (ser_clk && !p_sclk && ld != 3'b000) begin
                cur_bits = {cur_bits[78:0], ser_dat};
                cur_n++;
            end
            if (ser_clk) hi_cnt++;
            else begin
                if (p_sclk && hi_cnt != CLK_HALF) v_half++;
                hi_cnt = 0;
            end
            if (ld == 3'b000) gap_cnt++;
            else gap_cnt = 0;
            if (ld == 3'b000 && p_ld != 3'b000 && nfr < MAX_FR) begin
                fr_tgt[nfr]  = p_ld;
                fr_len[nfr]  = cur_n;
                fr_bits[nfr] = cur_bits;
                nfr++;
            end
            if (boot_done && !p_done) done_rises++;
            if (boot_done && (ser_oe || ser_clk || ser_dat || ld != 3'b000)) v_after++;
            p_sclk = ser_clk; p_dat = ser_dat; p_ld = ld; p_done = boot_done;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_reset_state(input string req);
        chk(ser_clk == 1'b0, req, "ser_clk in reset", 80'(ser_clk), 80'd0);
        chk(ser_dat == 1'b0, req, "ser_dat in reset", 80'(ser_dat), 80'd0);
        chk({dly_load, cha_load, chb_load} == 3'b000, req, "strobes in reset",
            80'({dly_load, cha_load, chb_load}), 80'd0);
        chk(ser_oe == 1'b1, req, "ser_oe in reset", 80'(ser_oe), 80'd1);
        chk(boot_done == 1'b0, req, "boot_done in reset", 80'(boot_done), 80'd0);
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (boot_done) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic check_boot(input string tag);
        bit ok;
        logic [2:0] addr;
        logic [7:0] data;
        logic       chb;
        logic [10:0] b;
        wait_done(ok);
        chk(ok, "R11", {tag, " boot_done reached"}, 80'(ok), 80'd1);
        repeat (60) @(posedge clk);
        // R1: power-settling wait
        chk(first_load >= PWR_WAIT, "R1", {tag, " first strobe not early"}, 80'(first_load), 80'(PWR_WAIT));
        chk(first_load <= PWR_WAIT + 8, "R1", {tag, " first strobe not late"}, 80'(first_load), 80'(PWR_WAIT + 8));
        chk(nfr == 17, "R4", {tag, " frame count"}, 80'(nfr), 80'd17);
        // R2: chain frame
        chk(fr_tgt[0] == 3'b100, "R2", {tag, " first frame target"}, 80'(fr_tgt[0]), 80'b100);
        chk(fr_len[0] == 80, "R2", {tag, " chain length"}, 80'(fr_len[0]), 80'd80);
        chk(fr_bits[0] == EXP_CHAIN, "R2", {tag, " chain payload"}, fr_bits[0], EXP_CHAIN);
        // R4/R5: converter writes, table walk
        for (int f = 0; f < 16; f++) begin
            b = fr_bits[f+1][10:0];
            addr = {b[8], b[9], b[10]};
            for (int j = 0; j < 8; j++) data[j] = b[7-j];
            chb = (fr_tgt[f+1] == 3'b001);
            chk(fr_len[f+1] == 11 && (fr_tgt[f+1] == 3'b010 || fr_tgt[f+1] == 3'b001),
                "R4", {tag, " converter frame shape"}, 80'({fr_tgt[f+1], 8'(fr_len[f+1])}),
                80'({EXP_CONV[f][11] ? 3'b001 : 3'b010, 8'd11}));
            chk({chb, addr, data} == EXP_CONV[f], "R5", {tag, " converter write"},
                80'({chb, addr, data}), 80'(EXP_CONV[f]));
        end
        chk(v_multi == 0 && v_noload == 0, "R6", {tag, " strobe exclusivity"}, 80'(v_multi + v_noload), 80'd0);
        chk(v_stable == 0, "R7", {tag, " data edge during high phase"}, 80'(v_stable), 80'd0);
        chk(v_half == 0, "R9", {tag, " high-phase length"}, 80'(v_half), 80'd0);
        chk(v_gap == 0, "R10", {tag, " inter-frame gap"}, 80'(v_gap), 80'd0);
        chk(done_rises == 1, "R11", {tag, " done rises once"}, 80'(done_rises), 80'd1);
        chk(v_after == 0 && !ser_oe, "R11", {tag, " bus released after done"}, 80'(v_after), 80'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (5) @(negedge clk);
        check_reset_state("R8");
        @(negedge clk) rst_n = 1'b1;
        check_boot("first boot");

        // second boot, cut off in the middle of the chain frame
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (dly_load) break;
        end
        repeat (100) @(negedge clk);
        chk(dly_load == 1'b1, "R12", "still inside chain frame", 80'(dly_load), 80'd1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_state("R12");
        rst_n = 1'b1;
        check_boot("restart");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule